// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Port

This block is the slave end of an 8-bit bus on which the address and the data share the same lines. The host places a location number on the bus and drops the address strobe. The block keeps the low 7 bits as the target of the access in a 128-byte register space. A data phase follows. In it the block either drives the bus with the addressed byte or takes a byte from the bus and hands it to the register file.

A static mode input sets how the two data-phase control pins are read. With the mode input high, one pin is a data strobe and the other gives the direction: high means read, low means write. A read is in progress while the strobe is high. A write is taken when the strobe falls. With the mode input low, the first pin is an active-low read strobe and the second is an active-low write strobe. A write is taken when the write strobe rises. The pad that feeds the mode input carries a weak pulldown, so an unconnected pin gives the second mode.

All bus pins are sampled by a fast local clock through two-flop synchronizers, and edges are found on the synchronized copies. The register file sees a location, a write byte, a one-cycle write enable and a one-cycle read enable. It returns the byte at the latched location on a read-data input.

Top module: `mux_bus_slave`

## Requirements
- R1: A falling edge of the address strobe loads bits 6..0 of the bus into `reg_addr`. Bit 7 is discarded.
- R2: In mode 1 (`mode_i`=1), with the data strobe high, the direction pin high and chip select low, `bus_oe` goes high and `bus_out` carries the byte the register file returned for the latched location.
- R3: In mode 1, a falling edge of the data strobe with the direction pin low and chip select low produces exactly one `reg_we` pulse. The pulse is one clock long, and `reg_wdata` holds the bus byte.
- R4: In mode 0 (`mode_i`=0), while the read strobe pin (`ds_i`) is low and chip select is low, `bus_oe` is high and `bus_out` carries the addressed byte.
- R5: In mode 0, a rising edge of the write strobe pin (`rw_i`) with chip select low produces exactly one one-clock `reg_wdata`/`reg_we` transfer of the bus byte.
- R6: `bus_oe` returns low within 4 clocks after the read strobe becomes inactive.
- R7: While chip select (`cs_n_i`) is high, a data phase produces no `reg_we`, no `reg_re` and no `bus_oe`.
- R8: A write to a location whose bit is set in the parameter `RO_MASK` produces no `reg_we`. By default only locations 0x0C and 0x0D are set.
- R9: Each read access produces exactly one `reg_re` pulse, however long the strobe is held.
- R10: After a synchronous active-low reset, `bus_oe`, `reg_we` and `reg_re` are low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1: strobe plus direction, 0: separate read/write strobes |
| as_i | input | 1 | Address strobe; falling edge latches the address |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_i | input | 1 | Direction, high = read (mode 1), or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select |
| bus_in | input | 8 | Bus value seen at the pads |
| bus_out | output | 8 | Read byte driven onto the bus |
| bus_oe | output | 1 | Pad output enable for the bus |
| reg_addr | output | 7 | Latched register location |
| reg_wdata | output | 8 | Write byte to the register file |
| reg_we | output | 1 | One-clock write enable |
| reg_re | output | 1 | One-clock read enable |
| reg_rdata | input | 8 | Byte returned by the register file for `reg_addr` |

## Verification
The case that is hardest to reach from the ports is a read strobe held for many clocks against a read-to-clear location. A level-based read enable would fire more than once in that case and clear the location repeatedly. The bench holds the read strobe for about forty clocks and counts `reg_re` pulses on the falling clock edge. The same pulse counters confirm that chip-select-off and read-only writes leave no trace. They also cover both modes and mode changes made while the bus is idle.

// File: rtl/mbs_pkg.sv
// Shared types for the multiplexed bus slave port.
package mbs_pkg;
    // Meaning of the data-phase control pins.
    typedef enum logic {
        MODE_SEPARATE   = 1'b0,  // read strobe low / write strobe low
        MODE_STROBE_DIR = 1'b1   // data strobe high plus direction pin
    } bus_mode_e;

    // Control pins carried through the synchronizer as one vector.
    localparam int CTRL_W    = 4;
    localparam int CTRL_AS   = 0;
    localparam int CTRL_DS   = 1;
    localparam int CTRL_RW   = 2;
    localparam int CTRL_CSN  = 3;
endpackage

// File: rtl/mbs_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL is the idle level of each pin.
module mbs_sync #(
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta;
        // Two register stages per bit, reset to the idle level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/mbs_phase_dec.sv
// Data-phase decoder: turns the synchronized strobe pins into a read-active
// level and a one-clock write-end event, according to the bus mode.
// Assumes inputs are already synchronized and mode only changes while idle.
module mbs_phase_dec
    import mbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode,
    input  logic      ds_s,
    input  logic      rw_s,
    input  logic      cs_n_s,
    output logic      rd_act,
    output logic      wr_end
);
    logic ds_q, rw_q;
    logic cs_act;

    assign cs_act = ~cs_n_s;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q <= 1'b1;
            rw_q <= 1'b1;
        end else begin
            ds_q <= ds_s;
            rw_q <= rw_s;
        end
    end

    // Per-mode meaning of the two control pins.
    always_comb begin
        if (mode == MODE_STROBE_DIR) begin
            rd_act = ds_s & rw_s & cs_act;
            wr_end = ds_q & ~ds_s & ~rw_s & cs_act;
        end else begin
            rd_act = ~ds_s & cs_act;
            wr_end = ~rw_q & rw_s & cs_act;
        end
    end

    // R3 R5: a write end is a single-clock event
    wr_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_end |=> !wr_end);
endmodule

// File: rtl/mbs_addr_latch.sv
// Address latch: loads the low bus bits on a falling address strobe.
// Assumes the bus value is synchronized with the same latency as the strobe.
module mbs_addr_latch #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s,
    input  logic [ADDR_W-1:0] bus_lo,
    output logic [ADDR_W-1:0] addr
);
    logic as_q;

    // Track strobe level and capture the address on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q <= 1'b1;
            addr <= '0;
        end else begin
            as_q <= as_s;
            if (as_q && !as_s) addr <= bus_lo;
        end
    end
endmodule

// File: rtl/mux_bus_slave.sv
// Slave port for a multiplexed address/data bus with two strobe modes.
// Assumes: bus pins asynchronous to clk, strobes held at least 4 clocks,
// data stable around the write trailing edge, reg_rdata combinational on reg_addr.
module mux_bus_slave
    import mbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK = (1 << 12) | (1 << 13)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              as_i,
    input  logic              ds_i,
    input  logic              rw_i,
    input  logic              cs_n_i,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam logic [CTRL_W-1:0] CTRL_IDLE = '1;

    logic [CTRL_W-1:0] ctrl_s;
    logic [DATA_W-1:0] bus_s;
    logic              rd_act, rd_q, wr_end;
    logic [DATA_W-1:0] rdata_q;

    mbs_sync #(.WIDTH(CTRL_W), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_i, rw_i, ds_i, as_i}), .q(ctrl_s));

    mbs_sync #(.WIDTH(DATA_W), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s));

    mbs_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .as_s(ctrl_s[CTRL_AS]),
        .bus_lo(bus_s[ADDR_W-1:0]), .addr(reg_addr));

    mbs_phase_dec u_dec (
        .clk(clk), .rst_n(rst_n), .mode(bus_mode_e'(mode_i)),
        .ds_s(ctrl_s[CTRL_DS]), .rw_s(ctrl_s[CTRL_RW]),
        .cs_n_s(ctrl_s[CTRL_CSN]), .rd_act(rd_act), .wr_end(wr_end));

    // Read phase state and the byte captured at the single read enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            rd_q <= rd_act;
            if (reg_re) rdata_q <= reg_rdata;
        end
    end

    assign reg_re    = rd_act & ~rd_q;
    assign bus_oe    = rd_act & rd_q;
    assign bus_out   = rdata_q;
    assign reg_wdata = bus_s;
    assign reg_we    = wr_end & ~RO_MASK[reg_addr];

    // R9
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R2
    oe_after_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(reg_re));

    // R3
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R6
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(rd_act));
endmodule

// File: tb/sim_mux_bus_slave.sv
`timescale 1ns/1ps
module sim_mux_bus_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b1, as_i = 1'b0, ds_i = 1'b0, rw_i = 1'b1, cs_n_i = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, reg_wdata, reg_rdata;
    logic [6:0] reg_addr;
    logic bus_oe, reg_we, reg_re;

    int checks = 0, fails = 0;
    int we_cnt = 0, re_cnt = 0;
    logic [7:0] last_wdata = '0;
    logic [6:0] last_waddr = '0;

    always #2.5 clk = ~clk;

    // Register file model: byte is a fixed function of the location.
    assign reg_rdata = {1'b0, reg_addr} ^ 8'hA5;

    mux_bus_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .as_i(as_i), .ds_i(ds_i),
        .rw_i(rw_i), .cs_n_i(cs_n_i), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                we_cnt++;
                last_wdata = reg_wdata;
                last_waddr = reg_addr;
            end
            if (reg_re) re_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        cs_n_i = 1'b1;
        mode_i = m;
        ds_i   = m ? 1'b0 : 1'b1;
        rw_i   = 1'b1;
        cyc(5);
    endtask

    // {mode, is_read, cs_ok, addr[6:0], data[7:0]}
    localparam logic [17:0] VEC [10] = '{
        {1'b1, 1'b0, 1'b1, 7'h05, 8'h3C},
        {1'b1, 1'b1, 1'b1, 7'h05, 8'h00},
        {1'b0, 1'b0, 1'b1, 7'h21, 8'hC3},
        {1'b0, 1'b1, 1'b1, 7'h21, 8'h00},
        {1'b1, 1'b0, 1'b1, 7'h0C, 8'h11},
        {1'b0, 1'b0, 1'b1, 7'h0D, 8'h22},
        {1'b1, 1'b1, 1'b0, 7'h10, 8'h00},
        {1'b0, 1'b0, 1'b0, 7'h11, 8'h44},
        {1'b0, 1'b1, 1'b1, 7'h7F, 8'h00},
        {1'b1, 1'b0, 1'b1, 7'h7F, 8'hFF}
    };

    // One bus access; returns nothing, checks are done inside.
    task automatic access(input logic m, input logic rd, input logic cs_ok,
                          input logic [6:0] a, input logic [7:0] d, input int hold);
        int we0, re0;
        logic ro;
        ro = (a == 7'h0C) || (a == 7'h0D);
        if (mode_i !== m) set_mode(m);
        we0 = we_cnt; re0 = re_cnt;
        // Address phase with a set bit 7 that must be dropped (R1).
        bus_in = {1'b1, a};
        as_i = 1'b1; cyc(4);
        as_i = 1'b0; cyc(5);
        chk("R1 addr latch", reg_addr, a);
        cs_n_i = cs_ok ? 1'b0 : 1'b1;
        if (rd) begin
            bus_in = 8'h00;
            if (m) begin rw_i = 1'b1; ds_i = 1'b1; end
            else   ds_i = 1'b0;
            cyc(hold);
            if (cs_ok) begin
                chk(m ? "R2 oe" : "R4 oe", bus_oe, 1'b1);
                chk(m ? "R2 data" : "R4 data", bus_out, {1'b0, a} ^ 8'hA5);
            end else begin
                chk("R7 no oe", bus_oe, 1'b0);
            end
            ds_i = m ? 1'b0 : 1'b1;
            cyc(4);
            chk("R6 oe release", bus_oe, 1'b0);
        end else begin
            bus_in = d;
            if (m) begin
                rw_i = 1'b0; cyc(2);
                ds_i = 1'b1; cyc(hold);
                ds_i = 1'b0; cyc(6);
                rw_i = 1'b1;
            end else begin
                rw_i = 1'b0; cyc(hold);
                rw_i = 1'b1; cyc(6);
            end
        end
        cs_n_i = 1'b1;
        cyc(4);
        chk(rd ? "R9 re count" : "R7 re count", re_cnt - re0, (rd && cs_ok) ? 1 : 0);
        chk(ro ? "R8 we count" : (cs_ok ? "R3/R5 we count" : "R7 we count"),
            we_cnt - we0, (!rd && cs_ok && !ro) ? 1 : 0);
        if (!rd && cs_ok && !ro) begin
            chk(m ? "R3 wdata" : "R5 wdata", last_wdata, d);
            chk(m ? "R3 waddr" : "R5 waddr", last_waddr, a);
        end
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(6);
        // R10 reset state
        chk("R10 oe", bus_oe, 1'b0);
        chk("R10 addr", reg_addr, 7'h00);
        chk("R10 we", we_cnt, 0);
        chk("R10 re", re_cnt, 0);

        foreach (VEC[i]) begin
            access(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14:8], VEC[i][7:0], 8);
        end

        // R9 long strobes in both modes: still a single read enable.
        access(1'b0, 1'b1, 1'b1, 7'h0C, 8'h00, 40);
        access(1'b1, 1'b1, 1'b1, 7'h0D, 8'h00, 40);
        // R5 long write strobe in separate mode.
        access(1'b0, 1'b0, 1'b1, 7'h40, 8'h5A, 30);

        // R10 reset in mid-read clears the drive.
        set_mode(1'b0);
        bus_in = 8'h03; as_i = 1'b1; cyc(4); as_i = 1'b0; cyc(5);
        cs_n_i = 1'b0; ds_i = 1'b0; cyc(8);
        rst_n = 1'b0; cyc(2);
        chk("R10 oe in reset", bus_oe, 1'b0);
        chk("R10 addr in reset", reg_addr, 7'h00);
        ds_i = 1'b1; cs_n_i = 1'b1; cyc(2);
        rst_n = 1'b1; cyc(6);
        chk("R10 oe after reset", bus_oe, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule